// File: doc/BRIEF.md
# Transactional Read/Write Set Buffer

This block is a small associative buffer placed beside a core's first-level cache. It records every location touched by the running hardware transaction. Loads add their address to the read set. Stores are held here with their bytes merged instead of going to memory. A later transactional load that finds a buffered store gets that data back, along with a mask that shows which bytes are valid. Addresses snooped from other cores are compared against every live entry, and a match reports a conflict abort.

The buffer has a fixed capacity of `ENTRIES` (8 by default) and never evicts. A new location that arrives when every slot is taken raises an overflow abort, and software then handles the transaction. On abort, the whole set is dropped in one cycle. On commit, the buffered stores are streamed out one per cycle in slot order, and then the set is emptied.

Top module: `txset_cam`

## Requirements
- R1: After reset the buffer is empty: `ld_hit`, `ovf_abort`, `conflict_abort`, `commit_busy` and `cm_valid` are all 0.
- R2: A load to an address not yet held takes the lowest free slot with only its read flag set. It reports no hit (`ld_hit`=0, `ld_data`=0, `ld_be`=0), and loading the same address again still reports no hit.
- R3: A store writes `st_data` lanes selected by `st_be` (bit i covers data bits 8i+7..8i) into the slot for its address, keeping lanes written earlier. In the same cycle, a load to an address whose slot holds store data gives `ld_hit`=1, the merged word on `ld_data` and the union of written lanes on `ld_be`. Lanes never written read as 0.
- R4: At most `ENTRIES` distinct addresses are held, each in exactly one slot. Repeat accesses to an address already held take no slot. A load or store to a new address while all slots are taken allocates nothing and pulses `ovf_abort` for one cycle in the following cycle.
- R5: A snoop whose address matches any held slot, whether read-only or written, pulses `conflict_abort` in the following cycle. A snoop that matches no slot does not.
- R6: A `commit_req` moves the block into a drain phase, starting in the next cycle. In each drain cycle, `cm_valid` presents one slot that holds store data, with `cm_addr`, `cm_data` and `cm_be`, in ascending slot order, and read-only slots are skipped. One further cycle follows with `commit_busy`=1 and `cm_valid`=0, after which every slot is empty and `commit_busy` is 0.
- R7: `abort_req` empties every slot at the next clock edge, overriding any other request in that cycle.
- R8: In the `commit_req` cycle and throughout the drain phase, loads, stores and snoops are ignored: no hit, no allocation, no conflict.
- R9: When a load and a store are requested in the same cycle, only the store is performed. The load reports no hit and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Transactional load request |
| ld_addr | input | AW | Load word address |
| ld_hit | output | 1 | Load found buffered store data (same cycle) |
| ld_data | output | DW | Buffered word on hit, else 0 |
| ld_be | output | DW/8 | Lanes of `ld_data` that are buffered |
| st_valid | input | 1 | Transactional store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store lane enables |
| snp_valid | input | 1 | Remote write or invalidation seen |
| snp_addr | input | AW | Snooped word address |
| commit_req | input | 1 | Begin commit drain |
| abort_req | input | 1 | Discard the transaction |
| ovf_abort | output | 1 | One-cycle overflow abort pulse |
| conflict_abort | output | 1 | One-cycle conflict abort pulse |
| commit_busy | output | 1 | Drain phase active |
| cm_valid | output | 1 | Commit write presented |
| cm_addr | output | AW | Commit write address |
| cm_data | output | DW | Commit write data |
| cm_be | output | DW/8 | Commit write lane enables |

## Verification
The buffer is tried with several access patterns. Loads alone to fresh addresses show that read-only slots never produce a hit. Two partial stores to one word, one covering the low lanes and one covering the high lanes, show the merge and the lane mask. A fill to exactly eight distinct addresses, followed by repeat accesses and then a ninth address, separates reuse of a held slot from overflow. A commit over interleaved read-only and store slots, with accesses and snoops driven into it, shows the slot ordering, the skipping of read-only slots and that the drain is quiet.

// File: rtl/txset_pkg.sv
package txset_pkg;
  typedef enum logic [0:0] {
    PH_RUN   = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;
endpackage

// File: rtl/txset_match.sv
module txset_match #(
  parameter int N  = 8,
  parameter int AW = 32
) (
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [N-1:0]         live,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hitv
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hitv[g] = live[g] && (tags[g] == key);
  end
endmodule

// File: rtl/txset_pick.sv
module txset_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any    = |req;
  assign onehot = req & (~req + N'(1));
endmodule

// File: rtl/txset_cam.sv
module txset_cam #(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic [DW/8-1:0] ld_be,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic          commit_req,
  input  logic          abort_req,
  output logic          ovf_abort,
  output logic          conflict_abort,
  output logic          commit_busy,
  output logic          cm_valid,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic [DW/8-1:0] cm_be
);
  import txset_pkg::*;

  localparam int BW = DW / 8;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [BW-1:0] lanes);
    logic [DW-1:0] r;
    for (int b = 0; b < BW; b++) begin
      r[8*b +: 8] = lanes[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return r;
  endfunction

  phase_t                      phase_q;
  logic [ENTRIES-1:0]          ent_v, ent_r, ent_w, pend_q;
  logic [ENTRIES-1:0][AW-1:0]  tag_q;
  logic [ENTRIES-1:0][DW-1:0]  dat_q;
  logic [ENTRIES-1:0][BW-1:0]  lane_q;

  // named internal events
  logic               running, do_st, do_ld, acc_hit, set_full;
  logic               req_new, overflow_ev, alloc_ev, snoop_ev;
  logic [AW-1:0]      acc_addr;
  logic [ENTRIES-1:0] acc_hitv, snp_hitv, acc_oh, free_oh, drn_oh;
  logic [IW-1:0]      acc_idx, free_idx, tgt_idx, drn_idx;
  logic               acc_any, free_any, drn_any;

  assign running  = (phase_q == PH_RUN) && !abort_req && !commit_req;
  assign do_st    = running && st_valid;
  assign do_ld    = running && ld_valid && !st_valid;
  assign acc_addr = st_valid ? st_addr : ld_addr;

  txset_match #(.N(ENTRIES), .AW(AW)) u_acc_match (
    .tags(tag_q), .live(ent_v), .key(acc_addr), .hitv(acc_hitv));
  txset_match #(.N(ENTRIES), .AW(AW)) u_snp_match (
    .tags(tag_q), .live(ent_v), .key(snp_addr), .hitv(snp_hitv));

  txset_pick #(.N(ENTRIES)) u_acc_pick (
    .req(acc_hitv), .any(acc_any), .idx(acc_idx), .onehot(acc_oh));
  txset_pick #(.N(ENTRIES)) u_free_pick (
    .req(~ent_v), .any(free_any), .idx(free_idx), .onehot(free_oh));
  txset_pick #(.N(ENTRIES)) u_drn_pick (
    .req(pend_q), .any(drn_any), .idx(drn_idx), .onehot(drn_oh));

  assign acc_hit     = acc_any;
  assign set_full    = !free_any;
  assign req_new     = (do_st || do_ld) && !acc_hit;
  assign overflow_ev = req_new && set_full;
  assign alloc_ev    = req_new && !set_full;
  assign tgt_idx     = acc_hit ? acc_idx : free_idx;
  assign snoop_ev    = running && snp_valid && (|snp_hitv);

  assign ld_hit  = do_ld && acc_hit && ent_w[acc_idx];
  assign ld_data = ld_hit ? dat_q[acc_idx] : '0;
  assign ld_be   = ld_hit ? lane_q[acc_idx] : '0;

  assign commit_busy = (phase_q == PH_DRAIN);
  assign cm_valid    = commit_busy && drn_any;
  assign cm_addr     = cm_valid ? tag_q[drn_idx] : '0;
  assign cm_data     = cm_valid ? dat_q[drn_idx] : '0;
  assign cm_be       = cm_valid ? lane_q[drn_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q        <= PH_RUN;
      ent_v          <= '0;
      ent_r          <= '0;
      ent_w          <= '0;
      pend_q         <= '0;
      tag_q          <= '0;
      dat_q          <= '0;
      lane_q         <= '0;
      ovf_abort      <= 1'b0;
      conflict_abort <= 1'b0;
    end else begin
      ovf_abort      <= overflow_ev;
      conflict_abort <= snoop_ev;
      if (abort_req) begin
        phase_q <= PH_RUN;
        ent_v   <= '0;
        ent_r   <= '0;
        ent_w   <= '0;
        pend_q  <= '0;
      end else if (phase_q == PH_DRAIN) begin
        if (drn_any) begin
          pend_q <= pend_q & ~drn_oh;
        end else begin
          phase_q <= PH_RUN;
          ent_v   <= '0;
          ent_r   <= '0;
          ent_w   <= '0;
        end
      end else if (commit_req) begin
        phase_q <= PH_DRAIN;
        pend_q  <= ent_v & ent_w;
      end else begin
        if (alloc_ev) begin
          ent_v[tgt_idx] <= 1'b1;
          tag_q[tgt_idx] <= acc_addr;
        end
        if (do_st && (acc_hit || alloc_ev)) begin
          ent_w[tgt_idx]  <= 1'b1;
          if (!acc_hit) ent_r[tgt_idx] <= 1'b0;
          dat_q[tgt_idx]  <= lane_merge(acc_hit ? dat_q[tgt_idx] : '0, st_data, st_be);
          lane_q[tgt_idx] <= (acc_hit ? lane_q[tgt_idx] : '0) | st_be;
        end
        if (do_ld && (acc_hit || alloc_ev)) begin
          ent_r[tgt_idx] <= 1'b1;
          if (!acc_hit) begin
            ent_w[tgt_idx]  <= 1'b0;
            dat_q[tgt_idx]  <= '0;
            lane_q[tgt_idx] <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/txset_cam_chk.sv
module txset_cam_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic               ld_hit,
  input logic               snp_valid,
  input logic               abort_req,
  input logic               ovf_abort,
  input logic               conflict_abort,
  input logic               commit_busy,
  input logic               cm_valid,
  input logic               req_new,
  input logic [ENTRIES-1:0] ent_v,
  input logic [ENTRIES-1:0] ent_r,
  input logic [ENTRIES-1:0] ent_w,
  input logic [ENTRIES-1:0] acc_hitv
);
  p_entry_flagged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_v & ~(ent_r | ent_w)) == '0);
  p_hit_needs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> ld_valid);
  p_unique_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_hitv));
  p_ovf_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_abort |-> ($past(&ent_v) && $past(req_new)));
  p_conflict_after_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_abort |-> $past(snp_valid));
  p_stream_in_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> commit_busy);
  p_abort_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (ent_v == '0));
  p_quiet_in_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_busy |-> !ld_hit);
endmodule

bind txset_cam txset_cam_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_hit(ld_hit),
  .snp_valid(snp_valid), .abort_req(abort_req), .ovf_abort(ovf_abort),
  .conflict_abort(conflict_abort), .commit_busy(commit_busy),
  .cm_valid(cm_valid), .req_new(req_new), .ent_v(ent_v), .ent_r(ent_r),
  .ent_w(ent_w), .acc_hitv(acc_hitv));

// File: tb/txset_cam_test.sv
module txset_cam_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, st_valid = 0, snp_valid = 0, commit_req = 0, abort_req = 0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0, snp_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [3:0] st_be = '0;
  logic ld_hit, ovf_abort, conflict_abort, commit_busy, cm_valid;
  logic [DW-1:0] ld_data, cm_data;
  logic [AW-1:0] cm_addr;
  logic [3:0] ld_be, cm_be;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txset_cam uut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .commit_req(commit_req), .abort_req(abort_req),
    .ovf_abort(ovf_abort), .conflict_abort(conflict_abort),
    .commit_busy(commit_busy), .cm_valid(cm_valid),
    .cm_addr(cm_addr), .cm_data(cm_data), .cm_be(cm_be));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_valid = 0; st_valid = 0; snp_valid = 0; commit_req = 0; abort_req = 0;
    st_be = '0;
  endtask

  // One access cycle: drive at negedge, check same-cycle load result,
  // then check the registered pulses just after the edge.
  task automatic op(input bit lv, input logic [AW-1:0] la,
                    input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd, input logic [3:0] sb,
                    input bit nv, input logic [AW-1:0] na,
                    input bit e_hit, input logic [DW-1:0] e_data, input logic [3:0] e_be,
                    input bit e_ovf, input bit e_conf, input string req);
    @(negedge clk);
    ld_valid = lv; ld_addr = la; st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    snp_valid = nv; snp_addr = na;
    #1;
    chk(ld_hit == e_hit, {req, " ld_hit"}, 64'(ld_hit), 64'(e_hit));
    if (lv) chk(ld_data == e_data && ld_be == e_be, {req, " ld_data/be"},
                {28'd0, ld_be, ld_data}, {28'd0, e_be, e_data});
    @(posedge clk); #1;
    idle_inputs();
    chk(ovf_abort == e_ovf, {req, " ovf_abort"}, 64'(ovf_abort), 64'(e_ovf));
    chk(conflict_abort == e_conf, {req, " conflict_abort"}, 64'(conflict_abort), 64'(e_conf));
  endtask

  task automatic ld(input logic [AW-1:0] a, input bit h, input logic [DW-1:0] d, input logic [3:0] b,
                    input bit ov, input string req);
    op(1, a, 0, 0, 0, 0, 0, 0, h, d, b, ov, 0, req);
  endtask

  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] b,
                    input bit ov, input string req);
    op(0, 0, 1, a, d, b, 0, 0, 0, 0, 0, ov, 0, req);
  endtask

  task automatic snp(input logic [AW-1:0] a, input bit c, input string req);
    op(0, 0, 0, 0, 0, 0, 1, a, 0, 0, 0, 0, c, req);
  endtask

  task automatic do_abort();
    @(negedge clk); abort_req = 1;
    @(posedge clk); #1; idle_inputs();
  endtask

  task automatic t_reset();
    chk(!ld_hit && !ovf_abort && !conflict_abort && !commit_busy && !cm_valid, "R1 reset outputs",
        {59'd0, ld_hit, ovf_abort, conflict_abort, commit_busy, cm_valid}, 64'd0);
  endtask

  task automatic t_load_alloc();
    do_abort();
    ld(32'h100, 0, 0, 0, 0, "R2 first load");
    ld(32'h100, 0, 0, 0, 0, "R2 repeat load");
    snp(32'h100, 1, "R5 snoop on read-only slot");
    snp(32'h104, 0, "R5 snoop miss");
  endtask

  task automatic t_store_merge();
    do_abort();
    st(32'h200, 32'h11223344, 4'b0011, 0, "R3 low lanes");
    st(32'h200, 32'hAABBCCDD, 4'b1100, 0, "R3 high lanes");
    ld(32'h200, 1, 32'hAABB3344, 4'b1111, 0, "R3 merged hit");
    st(32'h204, 32'h55667788, 4'b0100, 0, "R3 single lane");
    ld(32'h204, 1, 32'h00660000, 4'b0100, 0, "R3 unwritten lanes zero");
    ld(32'h208, 0, 0, 0, 0, "R3 read then store");
    st(32'h208, 32'hCAFEF00D, 4'b1111, 0, "R3 store over read slot");
    ld(32'h208, 1, 32'hCAFEF00D, 4'b1111, 0, "R3 hit after upgrade");
    snp(32'h200, 1, "R5 snoop on written slot");
  endtask

  task automatic t_same_cycle();
    do_abort();
    st(32'h300, 32'h0000BEEF, 4'b0011, 0, "R9 setup");
    op(1, 32'h300, 1, 32'h304, 32'h12345678, 4'b1111, 0, 0, 0, 0, 0, 0, 0, "R9 load dropped");
    ld(32'h304, 1, 32'h12345678, 4'b1111, 0, "R9 store done");
  endtask

  task automatic t_abort();
    do_abort();
    st(32'h400, 32'h1, 4'b1111, 0, "R7 setup");
    do_abort();
    snp(32'h400, 0, "R7 snoop after abort");
    ld(32'h400, 0, 0, 0, 0, "R7 load after abort");
  endtask

  task automatic t_overflow();
    do_abort();
    for (int i = 0; i < 8; i++) ld(32'h1000 + 32'(4 * i), 0, 0, 0, 0, "R4 fill");
    ld(32'h1000, 0, 0, 0, 0, "R4 repeat load when full");
    st(32'h1004, 32'h77, 4'b0001, 0, "R4 repeat store when full");
    ld(32'h1004, 1, 32'h77, 4'b0001, 0, "R4 store kept when full");
    ld(32'h2000, 0, 0, 0, 1, "R4 ninth load overflows");
    st(32'h2004, 32'h9, 4'b1111, 1, "R4 ninth store overflows");
    snp(32'h2004, 0, "R4 no slot taken");
  endtask

  task automatic t_commit();
    logic [AW-1:0] ea[3];
    logic [DW-1:0] ed[3];
    logic [3:0] eb[3];
    ea[0] = 32'h20; ed[0] = 32'hD1D1D1D1; eb[0] = 4'b1111;
    ea[1] = 32'h40; ed[1] = 32'h00220044; eb[1] = 4'b0101;
    ea[2] = 32'h50; ed[2] = 32'h0000E0E0; eb[2] = 4'b0011;
    do_abort();
    ld(32'h10, 0, 0, 0, 0, "R6 setup");
    st(32'h20, 32'hD1D1D1D1, 4'b1111, 0, "R6 setup");
    ld(32'h30, 0, 0, 0, 0, "R6 setup");
    st(32'h40, 32'h11223344, 4'b0101, 0, "R6 setup");
    st(32'h50, 32'hE0E0E0E0, 4'b0011, 0, "R6 setup");
    @(negedge clk);
    commit_req = 1; st_valid = 1; st_addr = 32'h60; st_data = 32'h1; st_be = 4'b1111;
    snp_valid = 1; snp_addr = 32'h20;
    @(posedge clk); #1;
    idle_inputs();
    chk(conflict_abort == 0, "R8 snoop in commit cycle", 64'(conflict_abort), 0);
    for (int k = 0; k < 3; k++) begin
      chk(commit_busy && cm_valid && cm_addr == ea[k] && cm_data == ed[k] && cm_be == eb[k],
          "R6 drain order", {cm_be, cm_addr[27:0], cm_data}, {eb[k], ea[k][27:0], ed[k]});
      snp_valid = 1; snp_addr = 32'h40;
      ld_valid = 1; ld_addr = 32'h20;
      #1;
      chk(ld_hit == 0, "R8 load in drain", 64'(ld_hit), 0);
      @(posedge clk); #1;
      idle_inputs();
      chk(conflict_abort == 0, "R8 snoop in drain", 64'(conflict_abort), 0);
    end
    chk(commit_busy && !cm_valid, "R6 final drain cycle", {62'd0, commit_busy, cm_valid}, 64'd2);
    @(posedge clk); #1;
    chk(!commit_busy, "R6 busy cleared", 64'(commit_busy), 0);
    snp(32'h10, 0, "R6 set emptied");
    ld(32'h20, 0, 0, 0, 0, "R6 store slot emptied");
    ld(32'h60, 0, 0, 0, 0, "R8 store in commit cycle dropped");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_load_alloc();
    t_store_merge();
    t_same_cycle();
    t_abort();
    t_overflow();
    t_commit();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule